// File: doc/BRIEF.md
# Exclusive Access Monitor

This block tracks one reservation per core for load-linked / store-conditional sequences. A load-exclusive request records the address of the 64-byte line it touches and arms the monitor. A later store-exclusive is allowed to write memory only while the monitor is still armed for that same line. The block then reports a one-bit status to the core. The data path of the load and the memory array are outside the block. The block drives only a write enable and a write address toward memory.

Several events disarm the reservation, so a store-conditional can fail even when the data in memory still matches:
- an explicit clear request, which software issues when its compare fails;
- an interrupt or context switch;
- eviction of the tracked line;
- a coherence event on the tracked line from another agent. A write always counts. Whether a read counts is set by a parameter.

The core reacts to a failure with its own retry loop. All outputs are registered and appear one cycle after the request.

Top module: `excl_monitor`

## Requirements
- R1: While `rst` is high on a clock edge, the registered outputs after that edge are `mon_armed`=0, `mem_we`=0, `stx_done`=0 and `stx_status`=0.
- R2: A request with `req_op`=1 (load-exclusive) arms the monitor on the line of `req_addr`, so `mon_armed` is 1 in the following cycle unless a disarm event of R13 applies.
- R3: A request with `req_op`=2 (store-exclusive) that finds the monitor armed on its line produces, one cycle later, `stx_done`=1, `stx_status`=0 (success), `mem_we`=1 and `mem_waddr`=`req_addr`.
- R4: A store-exclusive that finds the monitor disarmed produces `stx_done`=1, `stx_status`=1 (failure) and `mem_we`=0.
- R5: Every store-exclusive, whether it succeeds or fails, leaves `mon_armed`=0.
- R6: A store-exclusive to a line other than the armed one fails with status 1 and does not write.
- R7: Lines are `LINE_BYTES`=64 bytes wide, so address bits [5:0] are ignored when a request or event is compared with the tracked line.
- R8: A request with `req_op`=3 (clear) disarms the monitor. `req_op`=0 is idle and leaves the state unchanged.
- R9: `ctx_flush` high (interrupt or context switch) disarms the monitor whatever the addresses are.
- R10: `snp_valid` with `snp_write`=1 on the tracked line disarms the monitor. A snoop to another line leaves it armed.
- R11: A snoop read (`snp_write`=0) on the tracked line disarms the monitor only when `SNOOP_RD_CLR`=1. With the default of 0 it has no effect.
- R12: `evict_valid` on the tracked line disarms the monitor. An eviction of another line does not.
- R13: A disarm event in the same cycle as a request takes priority. A store-exclusive then fails. A load-exclusive whose line the event hits, or that coincides with `ctx_flush`, leaves the monitor disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request strobe |
| req_op | input | 2 | 0 idle, 1 load-exclusive, 2 store-exclusive, 3 clear |
| req_addr | input | ADDR_W | Byte address of the request |
| snp_valid | input | 1 | Coherence event from another agent |
| snp_write | input | 1 | 1 when that event is a write, 0 for a read |
| snp_addr | input | ADDR_W | Address of the coherence event |
| evict_valid | input | 1 | Line eviction strobe |
| evict_addr | input | ADDR_W | Address of the evicted line |
| ctx_flush | input | 1 | Interrupt or context switch |
| mon_armed | output | 1 | Registered monitor state |
| mem_we | output | 1 | Memory write enable for a successful store-exclusive |
| mem_waddr | output | ADDR_W | Address of that write |
| stx_done | output | 1 | Store-exclusive result is valid |
| stx_status | output | 1 | 0 success, 1 failure |

## Verification
The hardest cases to reach are disarm events that land in the same cycle as a request. They show whether the event is compared against the old tracked line or the new one, and whether it outranks the store. Directed sequences place a snoop write, an eviction or a flush exactly in the cycle of a store-exclusive or a load-exclusive. They also use addresses that differ only in the six offset bits, or only in the first line bit above them. A long random phase then draws requests and events with independent probabilities over three nearby lines with random offsets, so coincidences of every kind occur many times. Each cycle is compared against a reference model kept in the bench.

// File: rtl/excl_pkg.sv
package excl_pkg;
  typedef enum logic [1:0] {
    XOP_IDLE  = 2'd0,
    XOP_LOAD  = 2'd1,
    XOP_STORE = 2'd2,
    XOP_CLEAR = 2'd3
  } xop_e;
endpackage

// File: rtl/excl_line_cmp.sv
module excl_line_cmp #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6
) (
  input  logic [ADDR_W-1:0] a,
  input  logic [ADDR_W-1:0] b,
  output logic              same_line
);
  logic [ADDR_W-1:0] diff;
  always_comb begin
    diff      = (a ^ b) >> OFS_W;
    same_line = (diff == '0);
  end
endmodule

// File: rtl/excl_evt_decode.sv
module excl_evt_decode #(
  parameter int ADDR_W       = 32,
  parameter int OFS_W        = 6,
  parameter bit SNOOP_RD_CLR = 1'b0
) (
  input  logic [ADDR_W-1:0] line_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              ctx_flush,
  output logic              kill
);
  logic snp_hit, ev_hit, snp_counts;

  excl_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_snp_cmp (
    .a(snp_addr), .b(line_addr), .same_line(snp_hit)
  );
  excl_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_ev_cmp (
    .a(evict_addr), .b(line_addr), .same_line(ev_hit)
  );

  generate
    if (SNOOP_RD_CLR) begin : g_rd_clr
      assign snp_counts = snp_valid;
    end else begin : g_wr_only
      assign snp_counts = snp_valid & snp_write;
    end
  endgenerate

  assign kill = ctx_flush | (snp_counts & snp_hit) | (evict_valid & ev_hit);
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 64,
  parameter bit SNOOP_RD_CLR = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              evict_valid,
  input  logic [ADDR_W-1:0] evict_addr,
  input  logic              ctx_flush,
  output logic              mon_armed,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic              stx_done,
  output logic              stx_status
);
  import excl_pkg::*;

  localparam int OFS_W = $clog2(LINE_BYTES);

  xop_e              op;
  logic              is_ld, is_st, is_clr;
  logic [ADDR_W-1:0] tag_q, target;
  logic              armed_q, armed_d;
  logic              kill, st_hit, st_ok;

  always_comb begin
    op     = req_valid ? xop_e'(req_op) : XOP_IDLE;
    is_ld  = (op == XOP_LOAD);
    is_st  = (op == XOP_STORE);
    is_clr = (op == XOP_CLEAR);
    target = is_ld ? req_addr : tag_q;
  end

  excl_evt_decode #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SNOOP_RD_CLR(SNOOP_RD_CLR)
  ) u_evt (
    .line_addr(target),
    .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
    .evict_valid(evict_valid), .evict_addr(evict_addr),
    .ctx_flush(ctx_flush), .kill(kill)
  );

  excl_line_cmp #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_st_cmp (
    .a(req_addr), .b(tag_q), .same_line(st_hit)
  );

  always_comb begin
    st_ok   = is_st & armed_q & st_hit & ~kill;
    armed_d = armed_q;
    if (is_ld) armed_d = 1'b1;
    else if (is_st | is_clr) armed_d = 1'b0;
    if (kill) armed_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q    <= 1'b0;
      tag_q      <= '0;
      mem_we     <= 1'b0;
      mem_waddr  <= '0;
      stx_done   <= 1'b0;
      stx_status <= 1'b0;
    end else begin
      armed_q    <= armed_d;
      mem_we     <= st_ok;
      stx_done   <= is_st;
      stx_status <= is_st & ~st_ok;
      if (is_ld) tag_q <= req_addr;
      if (is_st) mem_waddr <= req_addr;
    end
  end

  assign mon_armed = armed_q;
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_op,
  input logic              ctx_flush,
  input logic              snp_valid,
  input logic              evict_valid,
  input logic              mon_armed,
  input logic              mem_we,
  input logic              stx_done,
  input logic              stx_status
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!mon_armed && !mem_we && !stx_done));

  a_r3_write_means_success: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (stx_done && !stx_status));

  a_r4_fail_no_write: assert property (@(posedge clk) disable iff (rst)
    (stx_done && stx_status) |-> !mem_we);

  a_r5_store_disarms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd2) |=> (!mon_armed && stx_done));

  a_r8_clear_disarms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd3) |=> !mon_armed);

  a_r9_flush_disarms: assert property (@(posedge clk) disable iff (rst)
    ctx_flush |=> !mon_armed);

  a_r2_load_arms: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 2'd1 && !ctx_flush && !snp_valid && !evict_valid)
      |=> mon_armed);
endmodule

bind excl_monitor excl_monitor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
  .ctx_flush(ctx_flush), .snp_valid(snp_valid), .evict_valid(evict_valid),
  .mon_armed(mon_armed), .mem_we(mem_we), .stx_done(stx_done),
  .stx_status(stx_status)
);

// File: tb/sim_excl_monitor.sv
module sim_excl_monitor;
  localparam int CLK_P  = 10;
  localparam int AW     = 32;
  localparam bit SNP_RD = 1'b0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [1:0]    req_op = 2'd0;
  logic [AW-1:0] req_addr = '0;
  logic          snp_valid = 1'b0, snp_write = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          evict_valid = 1'b0;
  logic [AW-1:0] evict_addr = '0;
  logic          ctx_flush = 1'b0;
  logic          mon_armed, mem_we, stx_done, stx_status;
  logic [AW-1:0] mem_waddr;

  int checks = 0;
  int errors = 0;
  bit m_armed = 1'b0;
  logic [AW-1:0] m_tag = '0;

  always #(CLK_P/2) clk = ~clk;

  excl_monitor #(.ADDR_W(AW), .LINE_BYTES(64), .SNOOP_RD_CLR(SNP_RD)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .snp_valid(snp_valid), .snp_write(snp_write),
    .snp_addr(snp_addr), .evict_valid(evict_valid), .evict_addr(evict_addr),
    .ctx_flush(ctx_flush), .mon_armed(mon_armed), .mem_we(mem_we),
    .mem_waddr(mem_waddr), .stx_done(stx_done), .stx_status(stx_status)
  );

  function automatic bit same_line(input logic [AW-1:0] a, input logic [AW-1:0] b);
    return a[AW-1:6] == b[AW-1:6];
  endfunction

  task automatic chk(input string rq, input string what, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] op, input logic [AW-1:0] a,
                     input logic sv, input logic sw, input logic [AW-1:0] sa,
                     input logic ev, input logic [AW-1:0] ea, input logic fl,
                     input string rq);
    logic [AW-1:0] tgt;
    bit kill, ok, n_arm;
    @(negedge clk);
    req_valid = (op != 2'd0); req_op = op; req_addr = a;
    snp_valid = sv; snp_write = sw; snp_addr = sa;
    evict_valid = ev; evict_addr = ea; ctx_flush = fl;
    tgt   = (op == 2'd1) ? a : m_tag;
    kill  = fl || (sv && (sw || SNP_RD) && same_line(sa, tgt)) || (ev && same_line(ea, tgt));
    ok    = (op == 2'd2) && m_armed && same_line(a, m_tag) && !kill;
    n_arm = (op == 2'd1) ? 1'b1 : ((op >= 2'd2) ? 1'b0 : m_armed);
    if (kill) n_arm = 1'b0;
    @(posedge clk); #1;
    chk(rq, "mon_armed", AW'(mon_armed), AW'(n_arm));
    chk(rq, "mem_we", AW'(mem_we), AW'(ok));
    chk(rq, "stx_done", AW'(stx_done), AW'(op == 2'd2));
    chk(rq, "stx_status", AW'(stx_status), AW'((op == 2'd2) && !ok));
    if (ok) chk(rq, "mem_waddr", mem_waddr, a);
    m_armed = n_arm;
    if (op == 2'd1) m_tag = a;
  endtask

  task automatic req(input logic [1:0] op, input logic [AW-1:0] a, input string rq);
    cyc(op, a, 1'b0, 1'b0, '0, 1'b0, '0, 1'b0, rq);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "mon_armed", AW'(mon_armed), '0);
    chk("R1", "mem_we", AW'(mem_we), '0);
    chk("R1", "stx_done", AW'(stx_done), '0);
    chk("R1", "stx_status", AW'(stx_status), '0);
    @(negedge clk); rst = 1'b0;

    // R2 arm, R7 same line with other offset, R3 success, R5 then disarmed
    req(2'd1, 32'h1000, "R2");
    req(2'd2, 32'h103F, "R7");
    req(2'd2, 32'h1000, "R5");
    req(2'd0, 32'h0, "R8");
    // R6 different line
    req(2'd1, 32'h1000, "R2");
    req(2'd2, 32'h1040, "R6");
    req(2'd2, 32'h1000, "R4");
    // R8 clear
    req(2'd1, 32'h2000, "R2");
    req(2'd0, 32'h0, "R8");
    req(2'd3, 32'h0, "R8");
    req(2'd2, 32'h2000, "R8");
    // R9 flush
    req(2'd1, 32'h2000, "R2");
    cyc(2'd0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, "R9");
    req(2'd2, 32'h2000, "R9");
    // R10 snoop writes
    req(2'd1, 32'h3000, "R2");
    cyc(2'd0, 0, 1'b1, 1'b1, 32'h3040, 1'b0, 0, 1'b0, "R10");
    cyc(2'd0, 0, 1'b1, 1'b1, 32'h3010, 1'b0, 0, 1'b0, "R10");
    req(2'd2, 32'h3000, "R10");
    // R11 snoop read ignored by default
    req(2'd1, 32'h3000, "R2");
    cyc(2'd0, 0, 1'b1, 1'b0, 32'h3008, 1'b0, 0, 1'b0, "R11");
    req(2'd2, 32'h3000, "R11");
    // R12 eviction
    req(2'd1, 32'h4000, "R2");
    cyc(2'd0, 0, 1'b0, 1'b0, 0, 1'b1, 32'h4040, 1'b0, "R12");
    cyc(2'd0, 0, 1'b0, 1'b0, 0, 1'b1, 32'h403C, 1'b0, "R12");
    req(2'd2, 32'h4000, "R12");
    // R13 same-cycle priority
    req(2'd1, 32'h5000, "R2");
    cyc(2'd2, 32'h5000, 1'b1, 1'b1, 32'h5020, 1'b0, 0, 1'b0, "R13");
    req(2'd1, 32'h5000, "R2");
    cyc(2'd2, 32'h5000, 1'b0, 1'b0, 0, 1'b1, 32'h5000, 1'b0, "R13");
    cyc(2'd1, 32'h5000, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, "R13");
    cyc(2'd1, 32'h6000, 1'b1, 1'b1, 32'h6004, 1'b0, 0, 1'b0, "R13");
    req(2'd1, 32'h5000, "R2");
    cyc(2'd1, 32'h6000, 1'b1, 1'b1, 32'h5000, 1'b0, 0, 1'b0, "R13");
    req(2'd2, 32'h6000, "R3");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] op;
      logic [AW-1:0] a, sa, ea;
      string rq;
      op = 2'($urandom % 4);
      a  = 32'h7000 + ($urandom % 3) * 64 + ($urandom % 64);
      sa = 32'h7000 + ($urandom % 3) * 64 + ($urandom % 64);
      ea = 32'h7000 + ($urandom % 3) * 64 + ($urandom % 64);
      rq = (op == 2'd2) ? "R3" : ((op == 2'd1) ? "R2" : "R13");
      cyc(op, a, ($urandom % 5) == 0, $urandom % 2, sa,
          ($urandom % 7) == 0, ea, ($urandom % 11) == 0, rq);
    end

    @(negedge clk);
    req_valid = 1'b0; snp_valid = 1'b0; evict_valid = 1'b0; ctx_flush = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule